// File: doc/BRIEF.md
# Host Bus Register Write Controller

This block is the slave side of a microprocessor-style host bus write into a small register file. The host marks a write with two active-low signals: a chip select and a write strobe. It presents a byte address and a byte-high-enable, and it places sixteen data bits on the bus. The controller samples every bus input through a two-flop synchronizer on its own clock. It then walks the handshake outputs through a fixed order: direction first, then buffer enable, then ready. Once the cycle ends, it drives ready high for one cycle and then lets it float.

An optional address strobe can capture the address, byte-high-enable and chip select. While the strobe is high the captured copy follows the pins. When the strobe drops, the copy freezes. Tying the strobe high makes the capture transparent, so the address is taken straight from the pins when the write starts.

The target register side supplies a busy flag. While it is set, ready is held back with wait states, up to a timeout that forces ready anyway. Ready is also held back until a minimum number of cycles has passed since the previous ready. The write is committed to the array on the same clock edge that asserts ready.

Top module: `hbw_ctrl`

## Requirements
- R1: After reset, `bus_ddir_n`, `bus_dben_n` and `bus_rdy_n` are 1, `bus_rdy_oe` is 0 and every register word reads 0.
- R2: A write cycle begins only while both the synchronized write strobe and the effective chip select are low. Either one low by itself leaves `bus_ddir_n` high.
- R3: After a write begins, `bus_ddir_n` goes low at least one cycle before `bus_dben_n` goes low.
- R4: `bus_rdy_n` is low only while `bus_dben_n` and `bus_ddir_n` are low and `bus_rdy_oe` is 1.
- R5: Let the first cycle in which `bus_dben_n` is low be cycle 0, and let `reg_busy` fall at the clock edge ending cycle B. Then `bus_rdy_n` first reads low in cycle min(B+1, WAIT_MAX) (default WAIT_MAX = 16), provided the spacing of R11 is already met.
- R6: The write is committed on the edge that drives `bus_rdy_n` low. Word index = address >> 1. Odd address: bits 15:8 of the data go to the upper byte only. Even address with byte-high-enable 0: all 16 bits are written. Even address with byte-high-enable 1: bits 7:0 go to the lower byte only. Word w appears at `regs_flat[16w+15:16w]`.
- R7: When the strobe or chip select returns high, `bus_ddir_n` and `bus_dben_n` rise in the same cycle. In that cycle `bus_rdy_n` = 1 with `bus_rdy_oe` = 1. In the next cycle `bus_rdy_oe` = 0.
- R8: While `bus_as` is high, the address, byte-high-enable and chip select are captured. After `bus_as` falls, later pin changes do not alter the target of the write.
- R9: With `bus_as` held high, the target is the address on the pins when the write starts.
- R10: If the write strobe was high for fewer than MIN_GAP synchronized cycles (default 3) before falling, that access is ignored: no direction, no ready and no register change.
- R11: Two successive falls of `bus_rdy_n` are at least RDY_SPACE cycles apart (default 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_as | input | 1 | Address strobe; high = capture/transparent |
| bus_rsel | input | ADDR_W | Byte address of the target register |
| bus_bhe_n | input | 1 | Byte-high-enable, active low |
| bus_data | input | 16 | Write data |
| reg_busy | input | 1 | Target register not ready; requests wait states |
| bus_ddir_n | output | 1 | Data direction, low during a write |
| bus_dben_n | output | 1 | Data buffer enable, active low |
| bus_rdy_n | output | 1 | Ready, active low |
| bus_rdy_oe | output | 1 | Ready output driver enable (0 = high impedance) |
| regs_flat | output | 2^(ADDR_W-1)*16 | Register array contents, word 0 in the low bits |

## Verification
The assertions assume the host keeps address, byte-high-enable and data steady from before the write strobe falls until ready has been seen. They also assume `reg_busy` changes only between edges. The bench therefore changes bus pins only on falling clock edges, and it sets the data and address several cycles before lowering the strobe. In strobe mode it scrambles the address and byte-enable only after the strobe has dropped, never during an open cycle. The bench drops the chip select and strobe only when the previous handshake has fully floated, except in the deliberate short-gap case.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_BEN,
    ST_ACK,
    ST_END
  } hbw_state_e;

  // Byte lanes touched by one write: bit 1 = upper byte, bit 0 = lower byte.
  function automatic logic [1:0] lane_mask(input logic odd_addr, input logic bhe_n);
    if (odd_addr)   return 2'b10;
    else if (!bhe_n) return 2'b11;
    else            return 2'b01;
  endfunction

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/hbw_alatch.sv
module hbw_alatch #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] sel_in,
  input  logic          bhe_n_in,
  input  logic          cs_n_in,
  output logic [AW-1:0] sel_o,
  output logic          bhe_n_o,
  output logic          cs_n_o
);

  logic [AW-1:0] sel_q;
  logic          bhe_n_q;
  logic          cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      bhe_n_q <= 1'b1;
      cs_n_q  <= 1'b1;
    end else if (strobe) begin
      sel_q   <= sel_in;
      bhe_n_q <= bhe_n_in;
      cs_n_q  <= cs_n_in;
    end
  end

  // Strobe high: pass through; strobe low: frozen copy.
  assign sel_o   = strobe ? sel_in   : sel_q;
  assign bhe_n_o = strobe ? bhe_n_in : bhe_n_q;
  assign cs_n_o  = strobe ? cs_n_in  : cs_n_q;

endmodule

// File: rtl/hbw_regfile.sv
module hbw_regfile
  import hbw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic                          bhe_n,
  input  logic [DATA_W-1:0]             wdata,
  output logic [(2**(AW-1))*DATA_W-1:0] regs_flat
);

  localparam int NREG  = 2 ** (AW - 1);
  localparam int LANES = DATA_W / 8;

  logic [1:0] mask;
  assign mask = lane_mask(waddr[0], bhe_n);

  for (genvar w = 0; w < NREG; w++) begin : g_word
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_flat[w*DATA_W + b*8 +: 8] <= '0;
        else if (we && (waddr[AW-1:1] == (AW-1)'(w)) && mask[b])
          regs_flat[w*DATA_W + b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
  import hbw_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int WAIT_MAX  = 16,
  parameter int MIN_GAP   = 3,
  parameter int RDY_SPACE = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_cs_n,
  input  logic                            bus_wr_n,
  input  logic                            bus_as,
  input  logic [ADDR_W-1:0]               bus_rsel,
  input  logic                            bus_bhe_n,
  input  logic [15:0]                     bus_data,
  input  logic                            reg_busy,
  output logic                            bus_ddir_n,
  output logic                            bus_dben_n,
  output logic                            bus_rdy_n,
  output logic                            bus_rdy_oe,
  output logic [(2**(ADDR_W-1))*16-1:0]   regs_flat
);

  localparam int SYNC_W = 4 + ADDR_W + DATA_W;
  localparam int WCNT_W = $clog2(WAIT_MAX + 1);
  localparam int GCNT_W = $clog2(MIN_GAP + 1);
  localparam int SCNT_W = $clog2(RDY_SPACE + 1);
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

  // Synchronized bus inputs
  logic [SYNC_W-1:0] sync_q;
  logic              as_s, cs_n_s, wr_n_s, bhe_n_s;
  logic [ADDR_W-1:0] sel_s;
  logic [DATA_W-1:0] data_s;

  hbw_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_as, bus_cs_n, bus_wr_n, bus_bhe_n, bus_rsel, bus_data}),
    .q     (sync_q)
  );

  assign {as_s, cs_n_s, wr_n_s, bhe_n_s, sel_s, data_s} = sync_q;

  // Address strobe capture
  logic [ADDR_W-1:0] sel_eff;
  logic              bhe_n_eff, cs_n_eff;

  hbw_alatch #(.AW(ADDR_W)) u_alatch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (as_s),
    .sel_in   (sel_s),
    .bhe_n_in (bhe_n_s),
    .cs_n_in  (cs_n_s),
    .sel_o    (sel_eff),
    .bhe_n_o  (bhe_n_eff),
    .cs_n_o   (cs_n_eff)
  );

  // Handshake sequencer
  hbw_state_e        state, state_nx;
  logic [WCNT_W-1:0] wait_cnt;
  logic [GCNT_W-1:0] wr_hi_cnt;
  logic [SCNT_W-1:0] since_rdy;
  logic [ADDR_W-1:0] cyc_sel;
  logic              cyc_bhe_n;

  // Named events for the checker
  logic bus_active, gap_ok, space_ok, tmo_hit;
  logic start_ev, end_ev, commit_ev;

  assign bus_active = !wr_n_s && !cs_n_eff;
  assign gap_ok     = (wr_hi_cnt == GCNT_W'(MIN_GAP));
  assign space_ok   = (since_rdy == SCNT_W'(RDY_SPACE - 1));
  assign tmo_hit    = (wait_cnt == WCNT_W'(WAIT_MAX - 1));
  assign start_ev   = (state == ST_IDLE) && bus_active && gap_ok;
  assign end_ev     = ((state == ST_DIR) || (state == ST_BEN) || (state == ST_ACK)) && !bus_active;
  assign commit_ev  = (state == ST_BEN) && bus_active && space_ok && (!reg_busy || tmo_hit);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start_ev) state_nx = ST_DIR;
      ST_DIR:  state_nx = end_ev ? ST_END : ST_BEN;
      ST_BEN:  if (end_ev) state_nx = ST_END;
               else if (commit_ev) state_nx = ST_ACK;
      ST_ACK:  if (end_ev) state_nx = ST_END;
      ST_END:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      wr_hi_cnt <= GCNT_W'(MIN_GAP);
      since_rdy <= SCNT_W'(RDY_SPACE - 1);
      cyc_sel   <= '0;
      cyc_bhe_n <= 1'b1;
    end else begin
      state <= state_nx;

      if (start_ev) begin
        cyc_sel   <= sel_eff;
        cyc_bhe_n <= bhe_n_eff;
      end

      if (start_ev)
        wait_cnt <= '0;
      else if ((state == ST_BEN) && !tmo_hit)
        wait_cnt <= wait_cnt + 1'b1;

      if (!wr_n_s)
        wr_hi_cnt <= '0;
      else if (!gap_ok)
        wr_hi_cnt <= wr_hi_cnt + 1'b1;

      if (commit_ev)
        since_rdy <= '0;
      else if (!space_ok)
        since_rdy <= since_rdy + 1'b1;
    end
  end

  // Moore decode of the bus handshake
  assign bus_ddir_n = !((state == ST_DIR) || (state == ST_BEN) || (state == ST_ACK));
  assign bus_dben_n = !((state == ST_BEN) || (state == ST_ACK));
  assign bus_rdy_n  = (state != ST_ACK);
  assign bus_rdy_oe = (state == ST_BEN) || (state == ST_ACK) || (state == ST_END);

  hbw_regfile #(.AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (commit_ev),
    .waddr     (cyc_sel),
    .bhe_n     (cyc_bhe_n),
    .wdata     (data_s),
    .regs_flat (regs_flat)
  );

endmodule

// File: rtl/hbw_ctrl_chk.sv
module hbw_ctrl_chk #(
  parameter int WAIT_MAX  = 16,
  parameter int RDY_SPACE = 12
) (
  input logic clk,
  input logic rst_n,
  input logic ddir_n,
  input logic dben_n,
  input logic rdy_n,
  input logic rdy_oe,
  input logic commit_ev
);

  localparam int LIM = WAIT_MAX + RDY_SPACE;

  int unsigned gap_cnt;
  int unsigned hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= RDY_SPACE - 1;
      hold_cnt <= 0;
    end else begin
      if (!rdy_n && $past(rdy_n))
        gap_cnt <= 0;
      else if (gap_cnt < RDY_SPACE)
        gap_cnt <= gap_cnt + 1;
      if (!dben_n && rdy_n)
        hold_cnt <= hold_cnt + 1;
      else
        hold_cnt <= 0;
    end
  end

  assert_dir_before_ben_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dben_n) |-> (!ddir_n && !$past(ddir_n)));

  assert_rdy_within_ben_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> (!dben_n && !ddir_n && rdy_oe));

  assert_wait_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dben_n && rdy_n) |-> (hold_cnt < LIM));

  assert_commit_gives_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> !rdy_n);

  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dben_n) |-> (ddir_n && rdy_n && rdy_oe));

  assert_float_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_oe) |-> ($past(rdy_n) && rdy_n && dben_n && ddir_n));

  assert_ready_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && $past(rdy_n)) |-> (gap_cnt >= RDY_SPACE - 1));

endmodule

bind hbw_ctrl hbw_ctrl_chk #(.WAIT_MAX(WAIT_MAX), .RDY_SPACE(RDY_SPACE)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ddir_n    (bus_ddir_n),
  .dben_n    (bus_dben_n),
  .rdy_n     (bus_rdy_n),
  .rdy_oe    (bus_rdy_oe),
  .commit_ev (commit_ev)
);

// File: tb/hbw_ctrl_tb.sv
module hbw_ctrl_tb_top;

  localparam int AW = 4;
  localparam int NREG = 2 ** (AW - 1);
  localparam int WMAX = 16;
  localparam int GAP = 3;
  localparam int SPACE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, as_h = 1'b1, bhe_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] rsel = '0;
  logic [15:0] data = '0;
  logic ddir_n, dben_n, rdy_n, rdy_oe;
  logic [NREG*16-1:0] regs;

  logic [15:0] model [NREG];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbw_ctrl #(.ADDR_W(AW), .WAIT_MAX(WMAX), .MIN_GAP(GAP), .RDY_SPACE(SPACE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_as(as_h),
    .bus_rsel(rsel), .bus_bhe_n(bhe_n), .bus_data(data), .reg_busy(busy),
    .bus_ddir_n(ddir_n), .bus_dben_n(dben_n), .bus_rdy_n(rdy_n), .bus_rdy_oe(rdy_oe),
    .regs_flat(regs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NREG*16-1:0] model_flat();
    logic [NREG*16-1:0] v;
    for (int w = 0; w < NREG; w++) v[w*16 +: 16] = model[w];
    return v;
  endfunction

  // Restatement of the lane rule: which bytes change, and from where.
  task automatic model_write(input int a, input bit bn, input logic [15:0] d);
    int w = a / 2;
    if (a % 2 == 1)      model[w] = {d[15:8], model[w][7:0]};
    else if (bn == 1'b0) model[w] = d;
    else                 model[w] = {model[w][15:8], d[7:0]};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One full write access with checks.
  task automatic do_write(input int a, input bit bn, input logic [15:0] d,
                          input int blen, input bit strobe_mode);
    int k, lat, expl;
    bit dir_seen, ben_seen, rdy_early, rel_seen;
    string mreq;
    mreq = strobe_mode ? "R8" : "R9";
    @(negedge clk);
    rsel = AW'(a); bhe_n = bn; data = d; busy = (blen > 0);
    if (strobe_mode) begin
      as_h = 1'b1; cs_n = 1'b0;
      idle(4);
      as_h = 1'b0;
      idle(3);
      rsel = ~AW'(a); bhe_n = ~bn;       // scrambled after capture
      idle(2);
    end else begin
      idle(2);
      cs_n = 1'b0;
    end
    wr_n = 1'b0;
    dir_seen = 0; ben_seen = 0; rdy_early = 0;
    for (int i = 0; i < 40 && !ben_seen; i++) begin
      @(negedge clk);
      if (!rdy_n) rdy_early = 1;
      if (!dben_n) ben_seen = 1;
      else if (!ddir_n) dir_seen = 1;
    end
    chk(ben_seen, "R3", "buffer enable reached", ben_seen, 1);
    chk(dir_seen, "R3", "direction low before buffer enable", dir_seen, 1);
    chk(!rdy_early, "R4", "no ready before buffer enable", rdy_early, 0);
    k = 0; lat = -1;
    while (k < 40 && lat < 0) begin
      if (k == blen) busy = 1'b0;
      @(negedge clk);
      k++;
      if (!rdy_n) begin
        lat = k;
        chk(!dben_n && !ddir_n && rdy_oe, "R4", "ready only with enables", {dben_n, ddir_n, rdy_oe}, 3'b001);
      end
    end
    busy = 1'b0;
    expl = (blen + 1 < WMAX) ? blen + 1 : WMAX;
    chk(lat == expl, "R5", "wait-state latency", lat, expl);
    model_write(a, bn, d);
    chk(regs[(a/2)*16 +: 16] == model[a/2], "R6", "written word", regs[(a/2)*16 +: 16], model[a/2]);
    chk(regs == model_flat(), mreq, "whole array after write", regs == model_flat(), 1);
    wr_n = 1'b1; cs_n = 1'b1;
    rel_seen = 0;
    for (int i = 0; i < 10 && !rel_seen; i++) begin
      @(negedge clk);
      if (dben_n) begin
        rel_seen = 1;
        chk(ddir_n && rdy_n && rdy_oe, "R7", "release cycle drives ready high",
            {ddir_n, rdy_n, rdy_oe}, 3'b111);
        @(negedge clk);
        chk(!rdy_oe && ddir_n && dben_n, "R7", "ready floats next cycle", rdy_oe, 0);
      end
    end
    chk(rel_seen, "R7", "release seen", rel_seen, 1);
    as_h = 1'b1;
    idle(20);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t0, t1, cyc, idx;
    bit moved;
    for (int w = 0; w < NREG; w++) model[w] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    chk(ddir_n && dben_n && rdy_n && !rdy_oe, "R1", "handshake idle after reset",
        {ddir_n, dben_n, rdy_n, rdy_oe}, 4'b1110);
    chk(regs == '0, "R1", "array cleared", regs == '0, 1);

    // R2: one of the two strobes alone does nothing
    moved = 0;
    cs_n = 1'b0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (!ddir_n) moved = 1; end
    cs_n = 1'b1;
    chk(!moved, "R2", "chip select alone", moved, 0);
    idle(4);
    moved = 0;
    wr_n = 1'b0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (!ddir_n) moved = 1; end
    wr_n = 1'b1;
    chk(!moved, "R2", "write strobe alone", moved, 0);
    chk(regs == '0, "R2", "array untouched", regs == '0, 1);
    idle(6);

    // Sweep: every byte address, both byte-high values, both address modes
    idx = 0;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 2 * NREG; a++) begin
        for (int bn = 0; bn < 2; bn++) begin
          do_write(a, bn[0], 16'hA55A ^ 16'(idx * 16'h1357), (idx * 7) % 21, m[0]);
          idx++;
        end
      end
    end

    // R10: short write-strobe gap, second access ignored
    @(negedge clk);
    rsel = 4'd2; bhe_n = 1'b0; data = 16'h1234;
    idle(2);
    cs_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < 40 && rdy_n; i++) @(negedge clk);
    model_write(2, 1'b0, 16'h1234);
    chk(regs == model_flat(), "R10", "first access written", regs == model_flat(), 1);
    wr_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0; data = 16'hBEEF;
    idle(4);
    moved = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!ddir_n || rdy_oe) moved = 1;
    end
    chk(!moved, "R10", "short-gap access ignored", moved, 0);
    chk(regs == model_flat(), "R10", "array unchanged", regs == model_flat(), 1);
    wr_n = 1'b1; cs_n = 1'b1;
    idle(20);

    // R11: back-to-back accesses, ready spacing
    @(negedge clk);
    rsel = 4'd4; bhe_n = 1'b0; data = 16'h0F0F;
    idle(2);
    cs_n = 1'b0; wr_n = 1'b0;
    t0 = -1; t1 = -1; cyc = 0;
    for (int i = 0; i < 60 && t0 < 0; i++) begin
      @(negedge clk); cyc++;
      if (!rdy_n) t0 = cyc;
    end
    wr_n = 1'b1; cs_n = 1'b1;
    idle(4); cyc += 4;
    data = 16'hF0F0;
    cs_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < 60 && t1 < 0; i++) begin
      @(negedge clk); cyc++;
      if (!rdy_n) t1 = cyc;
    end
    wr_n = 1'b1; cs_n = 1'b1;
    chk(t0 > 0 && t1 > 0, "R11", "both readies seen", t1, 1);
    chk((t1 - t0) == SPACE, "R11", "ready-to-ready spacing", t1 - t0, SPACE);
    model_write(4, 1'b0, 16'hF0F0);
    chk(regs == model_flat(), "R11", "second write landed", regs == model_flat(), 1);
    idle(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule